// File: doc/BRIEF.md
# Register Window Decoder with Self-Describing Modules

The block sits between a processor register bus and a set of peripheral modules. It claims a fixed 2 MB register window, splits it into 4 KB slices, and decides for each request whether it falls in a slice that a module owns, in a slice that nobody owns, or outside the window. A constant table in the package describes each module: its first slice, a 16-bit identifier, a two-part revision and a size code.

Each module announces itself. A read of the last word of its first slice returns an identification word, so software can scan the window and list what is present. Slices that no module owns read back a fixed filler word, which is easy to tell apart from a real register. A single scratch register per module stands in for the module's own control registers and shows that requests reach the right module. The bus is single-cycle: one request per clock, and the response appears one clock later.

Top module: `mmio_window_decoder`

## Requirements
- R1: Requests at 0x1BE00000 through 0x1BFFFFFF (the whole window, including unowned slices at both ends) raise busHit one clock later; requests outside the window leave busHit and busErr low and give zero read data.
- R2: Read data is registered: it shows the result of a read one clock after busRe, and it is zero in any cycle that follows a clock with no read.
- R3: A read at byte offset 0xFFC of a module's first slice returns {ID[31:16], major revision[15:12], minor revision[11:8], size code[7:0]}; the default table gives 0x01130100 at 0x1BE40FFC, 0x010A1000 at 0x1BE42FFC and 0x01082000 at 0x1BE47FFC.
- R4: The size code is the number of 4 KB slices the module owns minus one; the two-slice module at 0x1BF00000 reports 0x2B802001.
- R5: Only the first slice of a larger module carries the identification word; offset 0xFFC of its second slice (0x1BF01FFC) reads zero.
- R6: A read in a slice no module owns returns 0xDEADABBA; any read or write there sets busErr for exactly the one clock after the request, together with busHit.
- R7: Byte offset 0x000 of each module's first slice is a 32-bit read/write scratch register, reset to zero, separate for each module.
- R8: Writes to an identification word, to an unowned slice or outside the window change no scratch register and no identification word.
- R9: Every other address inside a module's slices reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| busAddr | input | 32 | Byte address of the request |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write request for this clock |
| busRe | input | 1 | Read request for this clock |
| busRdata | output | 32 | Read data, one clock after busRe |
| busHit | output | 1 | Request of the previous clock was inside the window |
| busErr | output | 1 | Request of the previous clock hit an unowned slice |

## Verification
The hardest case is a write that must have no effect, because nothing at the ports changes when it lands. The stimulus first loads recognisable values into the scratch registers, then writes to identification words, an unowned slice, the second slice of the large module and an address outside the window, and reads every scratch register and identification word back afterwards. The window edges are reached by addressing the lowest and highest words of the window and the words just beyond them.

// File: rtl/mmio_win_pkg.sv
package mmio_win_pkg;

  localparam int ADDR_W       = 32;
  localparam int DATA_W       = 32;
  localparam int WIN_ADDR_W   = 21;  // 2 MB window
  localparam int SLICE_ADDR_W = 12;  // 4 KB slice
  localparam int SLICE_IDX_W  = WIN_ADDR_W - SLICE_ADDR_W;
  localparam int NUM_MOD      = 4;

  localparam logic [SLICE_ADDR_W-1:0] ID_OFFSET      = 12'hFFC;
  localparam logic [SLICE_ADDR_W-1:0] SCRATCH_OFFSET = 12'h000;
  localparam logic [DATA_W-1:0]       FILLER_WORD    = 32'hDEADABBA;

  typedef struct packed {
    logic [SLICE_IDX_W-1:0] firstSlice;
    logic [15:0]            modId;
    logic [3:0]             revMajor;
    logic [3:0]             revMinor;
    logic [7:0]             sizeCode;   // slices owned minus one
  } modDesc_t;

  localparam modDesc_t MOD_TABLE [NUM_MOD] = '{
    '{firstSlice: 9'h040, modId: 16'h0113, revMajor: 4'd0, revMinor: 4'd1, sizeCode: 8'd0},
    '{firstSlice: 9'h042, modId: 16'h010A, revMajor: 4'd1, revMinor: 4'd0, sizeCode: 8'd0},
    '{firstSlice: 9'h047, modId: 16'h0108, revMajor: 4'd2, revMinor: 4'd0, sizeCode: 8'd0},
    '{firstSlice: 9'h100, modId: 16'h2B80, revMajor: 4'd2, revMinor: 4'd0, sizeCode: 8'd1}
  };

  typedef struct packed {
    logic               rdStb;
    logic               wrStb;
    logic               inWin;
    logic               unmapped;
    logic               idSel;
    logic               scratchSel;
    logic [NUM_MOD-1:0] modSel;
  } winStrobe_t;

  function automatic logic [DATA_W-1:0] idWord(input modDesc_t d);
    return {d.modId, d.revMajor, d.revMinor, d.sizeCode};
  endfunction

endpackage

// File: rtl/mmio_win_ctrl.sv
module mmio_win_ctrl
  import mmio_win_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h1BE00000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output winStrobe_t        stb
);

  localparam int CMP_W = SLICE_IDX_W + 1;

  logic                    inWin;
  logic [SLICE_IDX_W-1:0]  sliceIdx;
  logic [SLICE_ADDR_W-1:0] sliceOffs;
  logic [NUM_MOD-1:0]      modMatch;
  logic [NUM_MOD-1:0]      firstMatch;

  assign inWin     = busAddr[ADDR_W-1:WIN_ADDR_W] == BASE_ADDR[ADDR_W-1:WIN_ADDR_W];
  assign sliceIdx  = busAddr[WIN_ADDR_W-1:SLICE_ADDR_W];
  assign sliceOffs = busAddr[SLICE_ADDR_W-1:0];

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_match
    localparam logic [CMP_W-1:0] LO = CMP_W'(MOD_TABLE[m].firstSlice);
    localparam logic [CMP_W-1:0] HI = LO + CMP_W'(MOD_TABLE[m].sizeCode);
    logic [CMP_W-1:0] idxWide;
    assign idxWide       = {1'b0, sliceIdx};
    assign modMatch[m]   = inWin && (idxWide >= LO) && (idxWide <= HI);
    assign firstMatch[m] = inWin && (idxWide == LO);
  end

  always_comb begin
    stb            = '0;
    stb.rdStb      = busRe;
    stb.wrStb      = busWe;
    stb.inWin      = inWin;
    stb.modSel     = modMatch;
    stb.unmapped   = inWin && (modMatch == '0);
    stb.idSel      = |firstMatch && (sliceOffs == ID_OFFSET);
    stb.scratchSel = |firstMatch && (sliceOffs == SCRATCH_OFFSET);
  end

endmodule

// File: rtl/mmio_win_datapath.sv
module mmio_win_datapath
  import mmio_win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        stb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busHit,
  output logic              busErr
);

  logic [NUM_MOD-1:0][DATA_W-1:0] scratchQ;
  logic [DATA_W-1:0]              idMux;
  logic [DATA_W-1:0]              scratchMux;
  logic [DATA_W-1:0]              rdNext;
  logic                           access;

  assign access = stb.rdStb || stb.wrStb;

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_scratch
    always_ff @(posedge clk) begin
      if (!rstN)
        scratchQ[m] <= '0;
      else if (stb.wrStb && stb.scratchSel && stb.modSel[m])
        scratchQ[m] <= busWdata;
    end
  end

  always_comb begin
    idMux      = '0;
    scratchMux = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (stb.modSel[m]) begin
        idMux      = idMux | idWord(MOD_TABLE[m]);
        scratchMux = scratchMux | scratchQ[m];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdStb && stb.inWin) begin
      if (stb.unmapped)        rdNext = FILLER_WORD;
      else if (stb.idSel)      rdNext = idMux;
      else if (stb.scratchSel) rdNext = scratchMux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      busHit   <= 1'b0;
      busErr   <= 1'b0;
    end else begin
      busRdata <= rdNext;
      busHit   <= access && stb.inWin;
      busErr   <= access && stb.unmapped;
    end
  end

  // R1: at most one module owns a slice
  a_r1_single_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.modSel));

  // R1: requests outside the window are not claimed
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (access && !stb.inWin) |=> (!busHit && !busErr && busRdata == '0));

  // R6: unowned slice reads give the filler word and flag an error
  a_r6_filler: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && stb.unmapped) |=> (busRdata == FILLER_WORD && busErr));

  // R6: an error always comes with a hit
  a_r6_err_with_hit: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> busHit);

  // R8: ignored writes leave every scratch register alone
  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStb && (stb.unmapped || stb.idSel || !stb.inWin)) |=> $stable(scratchQ));

endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import mmio_win_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h1BE00000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWdata,
  input  logic        busWe,
  input  logic        busRe,
  output logic [31:0] busRdata,
  output logic        busHit,
  output logic        busErr
);

  winStrobe_t stb;

  mmio_win_ctrl #(.BASE_ADDR(BASE_ADDR)) i_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .stb     (stb)
  );

  mmio_win_datapath i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busHit   (busHit),
    .busErr   (busErr)
  );

endmodule

// File: tb/test_mmio_window_decoder.sv
`timescale 1ns/1ps
module test_mmio_window_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        busHit;
  logic        busErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rdata;
    logic        hit;
    logic        err;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  mmio_window_decoder i_mmio_window_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .busHit(busHit), .busErr(busErr)
  );

  task automatic compare(input string tag, input logic [31:0] rd, input logic h, input logic e,
                         input logic [31:0] xrd, input logic xh, input logic xe);
    checks++;
    if (rd !== xrd || h !== xh || e !== xe) begin
      errors++;
      $display("FAIL %s: got rdata=%h hit=%b err=%b, expected rdata=%h hit=%b err=%b",
               tag, rd, h, e, xrd, xh, xe);
    end
  endtask

  // monitor: outputs of the request driven at the previous falling edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      compare(it.tag, busRdata, busHit, busErr, it.rdata, it.hit, it.err);
    end
  end

  task automatic drive(input logic [31:0] a, input logic [31:0] wd, input logic we, input logic re,
                       input logic [31:0] xrd, input logic xh, input logic xe, input string tag);
    expItem_t it;
    @(negedge clk);
    busAddr = a; busWdata = wd; busWe = we; busRe = re;
    it.rdata = xrd; it.hit = xh; it.err = xe; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] xrd, input logic xh, input logic xe,
                    input string tag);
    drive(a, 32'h0, 1'b0, 1'b1, xrd, xh, xe, tag);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] wd, input logic xh, input logic xe,
                    input string tag);
    drive(a, wd, 1'b1, 1'b0, 32'h0, xh, xe, tag);
  endtask

  task automatic idle(input string tag);
    drive(32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #40000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    compare("R2 reset state", busRdata, busHit, busErr, 32'h0, 1'b0, 1'b0);

    // identification words
    rd(32'h1BE40FFC, 32'h01130100, 1, 0, "R3 id module0");
    rd(32'h1BE42FFC, 32'h010A1000, 1, 0, "R3 id module1");
    rd(32'h1BE47FFC, 32'h01082000, 1, 0, "R3 id module2");
    rd(32'h1BF00FFC, 32'h2B802001, 1, 0, "R4 id two-slice module");
    rd(32'h1BF01FFC, 32'h00000000, 1, 0, "R5 second slice 0xFFC");
    idle("R2 idle after read");

    // unowned slices
    rd(32'h1BE41FFC, 32'hDEADABBA, 1, 1, "R6 unowned read");
    wr(32'h1BE43000, 32'h5555AAAA, 1, 1, "R6 unowned write");
    idle("R6 error pulse ends");
    rd(32'h1BE00000, 32'hDEADABBA, 1, 1, "R1 window low edge");
    rd(32'h1BFFFFFC, 32'hDEADABBA, 1, 1, "R1 window high edge");

    // outside the window
    rd(32'h1C000000, 32'h0, 0, 0, "R1 above window");
    rd(32'h1BDFFFFC, 32'h0, 0, 0, "R1 below window");

    // scratch registers
    rd(32'h1BE40000, 32'h0, 1, 0, "R7 scratch reset");
    wr(32'h1BE40000, 32'hA5A50001, 1, 0, "R7 write module0");
    wr(32'h1BF00000, 32'h12345678, 1, 0, "R7 write module3");
    rd(32'h1BE40000, 32'hA5A50001, 1, 0, "R7 read module0");
    rd(32'h1BE42000, 32'h0, 1, 0, "R7 module1 independent");
    rd(32'h1BF00000, 32'h12345678, 1, 0, "R7 read module3");

    // ignored writes
    wr(32'h1BE42FFC, 32'hFFFFFFFF, 1, 0, "R8 write id");
    wr(32'h1BE41000, 32'hFFFFFFFF, 1, 1, "R8 write unowned");
    wr(32'h1C040000, 32'hFFFFFFFF, 0, 0, "R8 write outside");
    wr(32'h1BF01000, 32'hFFFFFFFF, 1, 0, "R9 write second slice");
    wr(32'h1BE40004, 32'hFFFFFFFF, 1, 0, "R9 write other offset");
    rd(32'h1BE42FFC, 32'h010A1000, 1, 0, "R8 id unchanged");
    rd(32'h1BE40000, 32'hA5A50001, 1, 0, "R8 module0 scratch unchanged");
    rd(32'h1BE42000, 32'h0, 1, 0, "R8 module1 scratch unchanged");
    rd(32'h1BE47000, 32'h0, 1, 0, "R8 module2 scratch unchanged");
    rd(32'h1BF00000, 32'h12345678, 1, 0, "R8 module3 scratch unchanged");
    rd(32'h1BF01000, 32'h0, 1, 0, "R9 second slice base");
    rd(32'h1BE40004, 32'h0, 1, 0, "R9 other offset");
    idle("R2 final idle");

    @(negedge clk);
    busRe = 1'b0; busWe = 1'b0;
    while (expQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule